// File: doc/BRIEF.md
# USB Endpoint Configuration and Data Toggle Control

This block holds the configuration word of one endpoint of a high-speed USB device controller and runs the control that goes with it. Firmware writes a 16-bit word that sets the transfer kind (isochronous, bulk or interrupt). The same word turns the endpoint buffer on, selects single or ping-pong buffering, and can suppress automatic empty packets. The packet engine sends a one-cycle strobe for each IN or OUT token. One cycle later the block returns a response: no answer, a data packet with its PID parity, an empty packet, NAK or STALL.

The engine reports a successful handshake with `xferOk`. The block then pulses a completion flag for the transaction direction. It also advances the DATA0/DATA1 parity and, when ping-pong buffering is on, moves to the other buffer half. If that half is not ready yet, the block holds the swap and answers NAK until the half becomes ready.

The parity is cleared only by a reset or by an enable bit written from 0 to 1. A stall leaves the parity untouched. In DMA mode a zero transfer length or a zero packet size makes the block answer IN with an empty packet, unless firmware has set the suppress bit.

Top module: `ep_xfer_ctrl`

## Requirements
- R1: Configuration word layout: bit 4 suppresses empty packets, bit 3 enables the endpoint, bit 2 selects ping-pong buffering, and bits 1:0 give the kind (01 isochronous, 10 bulk, 11 interrupt). A write is read back the next cycle with bits 15:5 reading 0.
- R2: Power-up reset (`rstN` low) and bus reset (`busReset` high for one cycle) both clear the configuration word, the data parity, the buffer half select and the completion flags.
- R3: The endpoint is active only when the enable bit is 1 and the kind is not 00. An inactive endpoint answers every token with response code 0 (none).
- R4: A token is answered one cycle later with `rspValid` high and a response code. The codes are 1 DATA, 2 empty packet, 3 NAK and 4 STALL. STALL has priority while `stallReq` is high. Otherwise the code is DATA when the current buffer half is ready, else NAK.
- R5: `xferOk` after a DATA or empty-packet answer to IN pulses `inDone` for one cycle. For non-isochronous kinds it also inverts `dataToggle`, in the cycle after `xferOk`.
- R6: A stall leaves the data parity unchanged, so the first data packet after the stall carries the parity from before it.
- R7: A write that changes the enable bit from 0 to 1 clears the data parity to DATA0. A write that leaves the enable bit at 1 keeps it.
- R8: Isochronous endpoints always answer with `rspPid` 0, and their completions leave `dataToggle` unchanged.
- R9: In DMA mode with the suppress bit at 0, an IN token is answered with the empty-packet code when `bufLen` or `maxPkt` is zero. With the suppress bit at 1 the normal answer is given. OUT tokens never get an empty packet.
- R10: Outside DMA mode, the suppress bit and zero lengths have no effect on the answer.
- R11: With ping-pong buffering on, `bufSel` moves to the other half in the cycle after a completed data transaction if that half is ready. With ping-pong off, `bufSel` is 0 and `halfReady[0]` alone decides.
- R12: If the other half is not ready at completion, `bufSel` stays put and every token is answered NAK until that half becomes ready. The block then swaps on its own.
- R13: An OUT token is answered DATA when the current half is ready. `xferOk` then pulses `outDone` and inverts the parity, for non-isochronous kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| busReset | input | 1 | USB bus reset, synchronous, active high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Configuration write data |
| cfgRdData | output | 16 | Configuration read data |
| dmaMode | input | 1 | Endpoint is served by DMA |
| bufLen | input | 16 | Programmed transfer length |
| maxPkt | input | 11 | Programmed max packet size |
| stallReq | input | 1 | Endpoint is stalled |
| tokIn | input | 1 | IN token strobe |
| tokOut | input | 1 | OUT token strobe |
| xferOk | input | 1 | Handshake of the pending transaction succeeded |
| halfReady | input | 2 | Buffer half ready, one bit per half |
| epActive | output | 1 | Endpoint enabled and configured |
| rspValid | output | 1 | Response present this cycle |
| rspKind | output | 3 | Response code |
| rspPid | output | 1 | Data PID parity, 0 = DATA0 |
| dataToggle | output | 1 | Current data parity |
| bufSel | output | 1 | Active buffer half |
| inDone | output | 1 | IN transaction completed |
| outDone | output | 1 | OUT transaction completed |

## Verification
Tokens are sent with each response-deciding input changed alone, in turn: stall, readiness of the current half, DMA mode with zero length or zero packet size, and the suppress bit. This separates the answer priorities and shows that the suppress bit matters only in DMA mode. Handshakes follow bulk, isochronous, OUT and empty-packet answers, so parity inversion can be told apart from completion alone. Enable is rewritten both as 1-to-1 and as 0-to-1, and tokens are sent during a stall, so parity clearing can be told apart from parity keeping. Ping-pong is run with the other half ready and with it not ready, so an immediate swap can be told apart from a deferred swap with NAK.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;

  typedef enum logic [1:0] {
    EP_UNSET = 2'b00,
    EP_ISO   = 2'b01,
    EP_BULK  = 2'b10,
    EP_INTR  = 2'b11
  } epKind_e;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_DATA  = 3'd1,
    RSP_ZLP   = 3'd2,
    RSP_NAK   = 3'd3,
    RSP_STALL = 3'd4
  } rspKind_e;

  // field order follows the configuration word, lsb last
  typedef struct packed {
    logic    noEmpty;
    logic    enable;
    logic    dblBuf;
    epKind_e kind;
  } epCfg_t;

  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_IN   = 2'd1,
    PD_OUT  = 2'd2
  } pend_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadRsp;
    rspKind_e rsp;
    logic     pidOdd;
    logic     flipTgl;
    logic     swapHalf;
    logic     doneIn;
    logic     doneOut;
  } ctlStrobe_t;

endpackage

// File: rtl/ep_dp.sv
module ep_dp
  import ep_ctl_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  ctlStrobe_t       stb,
  output logic [CFG_W-1:0] cfgRdData,
  output epCfg_t           cfg,
  output logic             toggle,
  output logic             bufSel,
  output logic             rspValid,
  output logic [2:0]       rspKind,
  output logic             rspPid,
  output logic             inDone,
  output logic             outDone
);

  localparam int FIELD_W = $bits(epCfg_t);
  localparam int PAD_W   = CFG_W - FIELD_W;
  localparam int EN_POS  = 3;

  epCfg_t cfgQ;
  epCfg_t wrCfg;
  logic   enRise;

  assign wrCfg  = epCfg_t'(cfgWrData[FIELD_W-1:0]);
  assign enRise = cfgWrEn && wrCfg.enable && !cfgQ.enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgQ <= '0;
    else if (busReset)    cfgQ <= '0;
    else if (cfgWrEn)     cfgQ <= wrCfg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             toggle <= 1'b0;
    else if (busReset)     toggle <= 1'b0;
    else if (enRise)       toggle <= 1'b0;
    else if (stb.flipTgl)  toggle <= ~toggle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bufSel <= 1'b0;
    else if (busReset)      bufSel <= 1'b0;
    else if (!cfgQ.dblBuf)  bufSel <= 1'b0;
    else if (stb.swapHalf)  bufSel <= ~bufSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspKind  <= RSP_NONE;
      rspPid   <= 1'b0;
      inDone   <= 1'b0;
      outDone  <= 1'b0;
    end else if (busReset) begin
      rspValid <= 1'b0;
      rspKind  <= RSP_NONE;
      rspPid   <= 1'b0;
      inDone   <= 1'b0;
      outDone  <= 1'b0;
    end else begin
      rspValid <= stb.loadRsp;
      if (stb.loadRsp) begin
        rspKind <= stb.rsp;
        rspPid  <= stb.pidOdd;
      end
      inDone  <= stb.doneIn;
      outDone <= stb.doneOut;
    end
  end

  assign cfg       = cfgQ;
  assign cfgRdData = {{PAD_W{1'b0}}, cfgQ};

  // R1
  cfg_readback_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    cfgWrEn |=> cfgRdData == {{PAD_W{1'b0}}, $past(cfgWrData[FIELD_W-1:0])});

  // R7
  tgl_clear_on_enable_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    (cfgWrEn && cfgWrData[EN_POS] && !cfgRdData[EN_POS]) |=> !toggle);

  // R6
  tgl_hold_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    (!stb.flipTgl && !cfgWrEn) |=> $stable(toggle));

endmodule

// File: rtl/ep_ctl.sv
module ep_ctl
  import ep_ctl_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  epCfg_t           cfg,
  input  logic             toggle,
  input  logic             bufSel,
  input  logic             dmaMode,
  input  logic [LEN_W-1:0] bufLen,
  input  logic [MPS_W-1:0] maxPkt,
  input  logic             stallReq,
  input  logic             tokIn,
  input  logic             tokOut,
  input  logic             xferOk,
  input  logic [1:0]       halfReady,
  output ctlStrobe_t       stb,
  output logic             active,
  output logic             swapWait
);

  pend_e    pend;
  logic     pendZlp;
  logic     isIso, tokAny, curReady, otherReady;
  logic     zeroLen, zlpWanted, compl, dataCompl, swapNow;
  rspKind_e rspNext;

  assign active     = cfg.enable && (cfg.kind != EP_UNSET);
  assign isIso      = (cfg.kind == EP_ISO);
  assign tokAny     = tokIn || tokOut;
  assign curReady   = halfReady[bufSel];
  assign otherReady = halfReady[~bufSel];
  assign zeroLen    = (bufLen == '0) || (maxPkt == '0);
  assign zlpWanted  = dmaMode && !cfg.noEmpty && zeroLen;

  always_comb begin
    if (!active)                rspNext = RSP_NONE;
    else if (stallReq)          rspNext = RSP_STALL;
    else if (tokIn && zlpWanted) rspNext = RSP_ZLP;
    else if (swapWait)          rspNext = RSP_NAK;
    else if (curReady)          rspNext = RSP_DATA;
    else                        rspNext = RSP_NAK;
  end

  assign compl     = xferOk && (pend != PD_IDLE) && !tokAny && active;
  assign dataCompl = compl && !pendZlp && cfg.dblBuf;
  assign swapNow   = active && cfg.dblBuf && otherReady && (dataCompl || swapWait);

  always_comb begin
    stb          = '0;
    stb.loadRsp  = tokAny;
    stb.rsp      = rspNext;
    stb.pidOdd   = toggle && !isIso;
    stb.flipTgl  = compl && !isIso;
    stb.swapHalf = swapNow;
    stb.doneIn   = compl && (pend == PD_IN);
    stb.doneOut  = compl && (pend == PD_OUT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= PD_IDLE;
      pendZlp  <= 1'b0;
      swapWait <= 1'b0;
    end else if (busReset || !active) begin
      pend     <= PD_IDLE;
      pendZlp  <= 1'b0;
      swapWait <= 1'b0;
    end else begin
      if (tokAny) begin
        if (rspNext == RSP_DATA || rspNext == RSP_ZLP)
          pend <= tokIn ? PD_IN : PD_OUT;
        else
          pend <= PD_IDLE;
        pendZlp <= (rspNext == RSP_ZLP);
      end else if (compl) begin
        pend    <= PD_IDLE;
        pendZlp <= 1'b0;
      end
      if (!cfg.dblBuf || swapNow) swapWait <= 1'b0;
      else if (dataCompl)         swapWait <= 1'b1;
    end
  end

  // R5
  done_one_dir_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    !(stb.doneIn && stb.doneOut));

  // R12
  wait_needs_dbl_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    swapWait |-> cfg.dblBuf);

endmodule

// File: rtl/ep_xfer_ctrl.sv
module ep_xfer_ctrl
  import ep_ctl_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             dmaMode,
  input  logic [LEN_W-1:0] bufLen,
  input  logic [MPS_W-1:0] maxPkt,
  input  logic             stallReq,
  input  logic             tokIn,
  input  logic             tokOut,
  input  logic             xferOk,
  input  logic [1:0]       halfReady,
  output logic             epActive,
  output logic             rspValid,
  output logic [2:0]       rspKind,
  output logic             rspPid,
  output logic             dataToggle,
  output logic             bufSel,
  output logic             inDone,
  output logic             outDone
);

  epCfg_t     cfg;
  ctlStrobe_t stb;
  logic       swapWait;

  ep_dp #(.CFG_W(CFG_W)) i_dp (
    .clk(clk), .rstN(rstN), .busReset(busReset),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .stb(stb),
    .cfgRdData(cfgRdData), .cfg(cfg), .toggle(dataToggle), .bufSel(bufSel),
    .rspValid(rspValid), .rspKind(rspKind), .rspPid(rspPid),
    .inDone(inDone), .outDone(outDone)
  );

  ep_ctl #(.LEN_W(LEN_W), .MPS_W(MPS_W)) i_ctl (
    .clk(clk), .rstN(rstN), .busReset(busReset),
    .cfg(cfg), .toggle(dataToggle), .bufSel(bufSel),
    .dmaMode(dmaMode), .bufLen(bufLen), .maxPkt(maxPkt),
    .stallReq(stallReq), .tokIn(tokIn), .tokOut(tokOut),
    .xferOk(xferOk), .halfReady(halfReady),
    .stb(stb), .active(epActive), .swapWait(swapWait)
  );

  // R3
  inactive_silent_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    ((tokIn || tokOut) && !epActive) |=> (rspValid && rspKind == RSP_NONE));

  // R6
  stall_answer_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    ((tokIn || tokOut) && epActive && stallReq && !cfgWrEn)
      |=> (rspKind == RSP_STALL && $stable(dataToggle)));

  // R8
  iso_pid_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    ((tokIn || tokOut) && epActive && cfgRdData[1:0] == 2'b01) |=> !rspPid);

  // R5
  in_done_cause_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    inDone |-> $past(xferOk));

  // R12
  wait_nak_chk: assert property (@(posedge clk) disable iff (!rstN || busReset)
    ((tokIn || tokOut) && epActive && swapWait && !stallReq && !(tokIn && dmaMode))
      |=> rspKind == RSP_NAK);

endmodule

// File: tb/test_ep_xfer_ctrl.sv
module test_ep_xfer_ctrl;

  logic        clk = 1'b0;
  logic        rstN, busReset, cfgWrEn, dmaMode, stallReq, tokIn, tokOut, xferOk;
  logic [15:0] cfgWrData, cfgRdData, bufLen;
  logic [10:0] maxPkt;
  logic [1:0]  halfReady;
  logic        epActive, rspValid, rspPid, dataToggle, bufSel, inDone, outDone;
  logic [2:0]  rspKind;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  ep_xfer_ctrl i_ep_xfer_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .dmaMode(dmaMode), .bufLen(bufLen), .maxPkt(maxPkt),
    .stallReq(stallReq), .tokIn(tokIn), .tokOut(tokOut), .xferOk(xferOk),
    .halfReady(halfReady), .epActive(epActive), .rspValid(rspValid),
    .rspKind(rspKind), .rspPid(rspPid), .dataToggle(dataToggle),
    .bufSel(bufSel), .inDone(inDone), .outDone(outDone)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrCfg(logic [15:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  // token, then check response (one register stage)
  task automatic token(logic isIn, string req, logic [2:0] expKind, logic expPid);
    @(negedge clk); tokIn = isIn; tokOut = !isIn;
    @(negedge clk); tokIn = 1'b0; tokOut = 1'b0;
    chk(req, "rspValid", rspValid, 1'b1);
    chk(req, "rspKind", rspKind, expKind);
    if (expKind == 3'd1 || expKind == 3'd2) chk(req, "rspPid", rspPid, expPid);
  endtask

  task automatic handshake(string req, logic expIn, logic expOut, logic expTgl);
    @(negedge clk); xferOk = 1'b1;
    @(negedge clk); xferOk = 1'b0;
    chk(req, "inDone", inDone, expIn);
    chk(req, "outDone", outDone, expOut);
    chk(req, "dataToggle", dataToggle, expTgl);
  endtask

  task automatic tReset();
    chk("R2", "cfgRdData", cfgRdData, 16'h0);
    chk("R2", "dataToggle", dataToggle, 1'b0);
    chk("R2", "rspValid", rspValid, 1'b0);
    chk("R2", "bufSel", bufSel, 1'b0);
  endtask

  task automatic tLayout();
    wrCfg(16'hFFFF);
    chk("R1", "cfgRdData", cfgRdData, 16'h001F);
    wrCfg(16'h0000);
    wrCfg(16'h0008);
    chk("R3", "epActive", epActive, 1'b0);
    token(1'b1, "R3", 3'd0, 1'b0);
  endtask

  task automatic tBulk();
    halfReady = 2'b01;
    wrCfg(16'h000A);
    chk("R3", "epActive", epActive, 1'b1);
    token(1'b1, "R4", 3'd1, 1'b0);
    handshake("R5", 1'b1, 1'b0, 1'b1);
    token(1'b1, "R5", 3'd1, 1'b1);
    handshake("R5", 1'b1, 1'b0, 1'b0);
    halfReady = 2'b00;
    token(1'b1, "R4", 3'd3, 1'b0);
    chk("R4", "dataToggle", dataToggle, 1'b0);
    halfReady = 2'b01;
  endtask

  task automatic tOut();
    token(1'b0, "R13", 3'd1, 1'b0);
    handshake("R13", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic tStall();
    stallReq = 1'b1;
    token(1'b1, "R6", 3'd4, 1'b0);
    chk("R6", "dataToggle", dataToggle, 1'b1);
    stallReq = 1'b0;
    token(1'b1, "R6", 3'd1, 1'b1);
    handshake("R6", 1'b1, 1'b0, 1'b0);
    token(1'b1, "R6", 3'd1, 1'b0);
    handshake("R6", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tEnable();
    wrCfg(16'h000A);
    chk("R7", "toggle kept", dataToggle, 1'b1);
    wrCfg(16'h0002);
    token(1'b1, "R3", 3'd0, 1'b0);
    wrCfg(16'h000A);
    chk("R7", "toggle cleared", dataToggle, 1'b0);
    token(1'b1, "R7", 3'd1, 1'b0);
  endtask

  task automatic tZlp();
    dmaMode = 1'b1; bufLen = 16'd0;
    token(1'b1, "R9", 3'd2, 1'b0);
    handshake("R9", 1'b1, 1'b0, 1'b1);
    bufLen = 16'd64; maxPkt = 11'd0;
    token(1'b1, "R9", 3'd2, 1'b1);
    token(1'b0, "R9", 3'd1, 1'b1);
    wrCfg(16'h001A);
    token(1'b1, "R9", 3'd1, 1'b1);
    dmaMode = 1'b0; bufLen = 16'd0;
    token(1'b1, "R10", 3'd1, 1'b1);
    wrCfg(16'h000A);
    token(1'b1, "R10", 3'd1, 1'b1);
    bufLen = 16'd64; maxPkt = 11'd512;
  endtask

  task automatic tIso();
    wrCfg(16'h0009);
    token(1'b1, "R8", 3'd1, 1'b0);
    handshake("R8", 1'b1, 1'b0, 1'b1);
    token(1'b1, "R8", 3'd1, 1'b0);
  endtask

  task automatic tPingPong();
    wrCfg(16'h0002);
    wrCfg(16'h000E);
    halfReady = 2'b11;
    chk("R11", "bufSel", bufSel, 1'b0);
    token(1'b1, "R11", 3'd1, 1'b0);
    handshake("R11", 1'b1, 1'b0, 1'b1);
    chk("R11", "bufSel swap", bufSel, 1'b1);
    halfReady = 2'b01;
    token(1'b1, "R11", 3'd3, 1'b0);
    halfReady = 2'b11;
    token(1'b1, "R12", 3'd1, 1'b1);
    halfReady = 2'b10;
    handshake("R12", 1'b1, 1'b0, 1'b0);
    chk("R12", "bufSel held", bufSel, 1'b1);
    token(1'b1, "R12", 3'd3, 1'b0);
    halfReady = 2'b11;
    @(negedge clk);
    chk("R12", "bufSel late swap", bufSel, 1'b0);
    token(1'b1, "R12", 3'd1, 1'b0);
    handshake("R11", 1'b1, 1'b0, 1'b1);
    chk("R11", "bufSel", bufSel, 1'b1);
    wrCfg(16'h000A);
    @(negedge clk);
    chk("R11", "bufSel single", bufSel, 1'b0);
  endtask

  task automatic tBusReset();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
    chk("R2", "cfgRdData", cfgRdData, 16'h0);
    chk("R2", "dataToggle", dataToggle, 1'b0);
    chk("R2", "epActive", epActive, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; busReset = 1'b0; cfgWrEn = 1'b0; cfgWrData = '0;
    dmaMode = 1'b0; bufLen = 16'd64; maxPkt = 11'd512; stallReq = 1'b0;
    tokIn = 1'b0; tokOut = 1'b0; xferOk = 1'b0; halfReady = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLayout();
    tBulk();
    tOut();
    tStall();
    tEnable();
    tZlp();
    tIso();
    tPingPong();
    tBusReset();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule